// File: doc/BRIEF.md
# Transmit Pause Quantum Timer

This block sits beside a MAC transmitter and enforces flow-control hold-off. Each valid pause frame that the receive side decodes arrives here as a single-cycle event carrying a 16-bit quantum. When pausing is allowed, the block loads the quantum into a down counter and withholds permission to start new transmit frames until the counter has drained. One quantum is 512 bit times. With a 4-bit line interface, this is 128 line strobes at either line speed. The bench drives the line strobe at the rate of the selected speed. A fast test mode removes the prescaler, so the counter then steps once per receive-clock strobe.

Frame starts use a valid/ready handshake. The transmitter raises `tx_start_valid` and must hold it until `tx_start_ready` is high; a start is taken in a cycle where both are high. Ready is low only while a pause is active. A frame that has already started is never cut: the gate acts only at frame start. The block also counts every valid pause frame, and this count saturates.

Top module: `pause_quantum_timer`

## Requirements
- R1: After reset `tx_paused` is 0, `tx_start_ready` is 1 and `pframe_count` is 0.
- R2: An event starts or changes a pause only if `pause_en` is 1 when the event arrives; with `pause_en` 0 the event leaves `tx_paused` at 0, and a zero quantum with no active pause starts nothing.
- R3: With `test_fast` 0, the counter steps down once for every 128 cycles in which `line_stb` is 1, counted from the load. `tx_paused` is high for exactly that many cycles in total: 128 line strobes per quantum, which is Q*128 cycles when the strobe is continuous.
- R4: With `test_fast` 1, the counter steps down on every cycle in which `rx_stb` is 1, so a quantum Q with `rx_stb` held high pauses for Q cycles.
- R5: An accepted event during an active pause reloads the counter with its quantum and restarts the 128-strobe sub-count.
- R6: An accepted event with quantum 0 ends an active pause: `tx_paused` is 0 in the next cycle.
- R7: `tx_start_ready` is 0 exactly while `tx_paused` is 1. A start request held during a pause is accepted once the pause ends.
- R8: `pframe_count` increments by one on every cycle in which `pframe_valid` is 1, whatever the values of `pause_en`, `pfc_done` and the quantum.
- R9: `pframe_count` stops at its all-ones value and does not wrap.
- R10: With `pfc_done` 1, an event is ignored by the timer: it neither starts a pause nor reloads or shortens one that is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pause_en | input | 1 | Allows pause events to act on the timer |
| pfc_done | input | 1 | Priority flow control negotiated; the timer ignores events |
| test_fast | input | 1 | 1: step per `rx_stb`; 0: step per 128 `line_stb` |
| line_stb | input | 1 | One pulse per line nibble time |
| rx_stb | input | 1 | Receive clock strobe, used in fast test mode |
| pframe_valid | input | 1 | One-cycle event: a valid pause frame was received |
| pframe_quanta | input | 16 | Pause quantum carried with the event |
| tx_start_valid | input | 1 | Transmitter requests a new frame start |
| tx_start_ready | output | 1 | A frame start may be taken this cycle |
| tx_paused | output | 1 | Pause counter is non-zero |
| pframe_count | output | STAT_W | Saturating count of valid pause frames |

## Verification
The bench measures how long each pause lasts in cycles. It compares that length with a value computed from the quantum, the mode and the strobe pattern. A timer that drops the pause one cycle late, or that keeps the old prescaler phase after a load, shows up as an off-by-one or an off-by-128 length. Reloads and zero quanta are sent part way through a pause. A design that ignores the reload gives the old length, and one that only stops stepping never releases `tx_paused`. Events are also sent with `pfc_done` set and with pausing disabled; a design that lets these through starts or changes a pause. The count is pushed past its limit, and a wrapping design then reads back a small number.

// File: rtl/ptq_pkg.sv
package ptq_pkg;
  localparam int QUANTA_W = 16;
  localparam int BIT_TIMES_PER_QUANTUM = 512;

  typedef logic [QUANTA_W-1:0] quanta_t;

  typedef enum logic {
    STEP_LINE = 1'b0,
    STEP_FAST = 1'b1
  } step_mode_e;
endpackage

// File: rtl/ptq_step_gen.sv
module ptq_step_gen
  import ptq_pkg::*;
#(
  parameter int STROBES = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  step_mode_e mode,
  input  logic       restart,
  input  logic       line_stb,
  input  logic       fast_stb,
  output logic       step
);
  logic line_step;

  generate
    if (STROBES > 1) begin : g_prescale
      localparam int PRE_W = $clog2(STROBES);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(STROBES - 1);
      logic [PRE_W-1:0] pre_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pre_q <= '0;
        end else if (restart) begin
          pre_q <= '0;
        end else if (mode == STEP_LINE && line_stb) begin
          pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
        end
      end

      assign line_step = line_stb && (pre_q == PRE_LAST);
    end else begin : g_direct
      assign line_step = line_stb;
    end
  endgenerate

  always_comb begin
    unique case (mode)
      STEP_FAST: step = fast_stb;
      default:   step = line_step;
    endcase
  end

  AST_FAST_STEP_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == STEP_FAST && step) |-> fast_stb); // R4
  AST_LINE_STEP_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == STEP_LINE && step) |-> line_stb); // R3
endmodule

// File: rtl/ptq_down_counter.sv
module ptq_down_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic         active
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (step && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active = (cnt_q != '0);

  AST_LOAD_TAKES_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val))); // R5
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3
  AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(cnt_q)); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q == '0) |=> (cnt_q == '0)); // R3
endmodule

// File: rtl/ptq_sat_counter.sv
module ptq_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;
  logic [W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (inc && count_q != TOP) begin
      count_q <= count_q + 1'b1;
    end
  end

  assign count = count_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == TOP) |=> (count_q == TOP)); // R9
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && count_q != TOP) |=> (count_q == $past(count_q) + 1'b1)); // R8
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(count_q)); // R8
endmodule

// File: rtl/pause_quantum_timer.sv
module pause_quantum_timer
  import ptq_pkg::*;
#(
  parameter int LINE_BITS = 4,
  parameter int STAT_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pause_en,
  input  logic              pfc_done,
  input  logic              test_fast,
  input  logic              line_stb,
  input  logic              rx_stb,
  input  logic              pframe_valid,
  input  logic [15:0]       pframe_quanta,
  input  logic              tx_start_valid,
  output logic              tx_start_ready,
  output logic              tx_paused,
  output logic [STAT_W-1:0] pframe_count
);
  localparam int STROBES_PER_STEP = BIT_TIMES_PER_QUANTUM / LINE_BITS;

  logic       accept;
  logic       step;
  step_mode_e mode;
  quanta_t    quanta;

  assign accept = pframe_valid && pause_en && !pfc_done;
  assign mode   = test_fast ? STEP_FAST : STEP_LINE;
  assign quanta = pframe_quanta;

  ptq_step_gen #(
    .STROBES (STROBES_PER_STEP)
  ) u_step (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .restart  (accept),
    .line_stb (line_stb),
    .fast_stb (rx_stb),
    .step     (step)
  );

  ptq_down_counter #(
    .W (QUANTA_W)
  ) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (quanta),
    .step     (step),
    .active   (tx_paused)
  );

  ptq_sat_counter #(
    .W (STAT_W)
  ) u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (pframe_valid),
    .count (pframe_count)
  );

  assign tx_start_ready = !tx_paused;

  AST_IGNORED_EVENT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pframe_valid && (!pause_en || pfc_done) && !tx_paused) |=> !tx_paused); // R2
  AST_ZERO_QUANTUM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (pframe_valid && pause_en && !pfc_done && pframe_quanta == 16'd0) |=> !tx_paused); // R6
  AST_NONZERO_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (pframe_valid && pause_en && !pfc_done && pframe_quanta != 16'd0) |=> tx_paused); // R5
  AST_START_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start_valid && !tx_start_ready) |=> tx_start_valid); // R7
endmodule

// File: tb/pause_quantum_timer_bench.sv
module pause_quantum_timer_bench;
  localparam int STAT_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pause_en = 1'b1;
  logic pfc_done = 1'b0;
  logic test_fast = 1'b0;
  logic line_stb = 1'b1;
  logic rx_stb = 1'b1;
  logic pframe_valid = 1'b0;
  logic [15:0] pframe_quanta = '0;
  logic tx_start_valid = 1'b0;
  logic tx_start_ready;
  logic tx_paused;
  logic [STAT_W-1:0] pframe_count;

  int checks = 0;
  int fails = 0;
  int exp_stat = 0;
  int run_len = 0;
  int exp_q[$];
  string tag_q[$];
  logic half_rate = 1'b0;

  always #4 clk = ~clk;

  pause_quantum_timer #(.LINE_BITS(4), .STAT_W(STAT_W)) u_pause_quantum_timer (
    .clk(clk), .rst_n(rst_n), .pause_en(pause_en), .pfc_done(pfc_done),
    .test_fast(test_fast), .line_stb(line_stb), .rx_stb(rx_stb),
    .pframe_valid(pframe_valid), .pframe_quanta(pframe_quanta),
    .tx_start_valid(tx_start_valid), .tx_start_ready(tx_start_ready),
    .tx_paused(tx_paused), .pframe_count(pframe_count)
  );

  always @(posedge clk) #2 line_stb = half_rate ? ~line_stb : 1'b1;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Driver: called at a negedge; raises the event for one cycle.
  task automatic send(input logic [15:0] q);
    pframe_quanta = q;
    pframe_valid = 1'b1;
    exp_stat++;
    @(negedge clk);
    pframe_valid = 1'b0;
  endtask

  task automatic expect_pause(input int len, input string req);
    exp_q.push_back(len);
    tag_q.push_back(req);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (tx_paused);
    @(negedge clk);
  endtask

  // Monitor: measures each pause and compares with the scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_paused) begin
        run_len++;
      end else if (run_len > 0) begin
        if (exp_q.size() == 0) begin
          check("unexpected pause", run_len, 0);
        end else begin
          check(tag_q.pop_front(), run_len, exp_q.pop_front());
        end
        run_len = 0;
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 paused", tx_paused, 0);
    check("R1 ready", tx_start_ready, 1);
    check("R1 count", pframe_count, 0);

    // R3: two quanta, continuous line strobe
    expect_pause(256, "R3 continuous");
    send(16'd2);
    wait_idle();

    // R4: fast test mode
    test_fast = 1'b1;
    expect_pause(5, "R4 fast");
    send(16'd5);
    wait_idle();
    test_fast = 1'b0;

    // R3: line strobe every other cycle, first strobe right after load
    half_rate = 1'b1;
    line_stb = 1'b0;
    expect_pause(255, "R3 half rate");
    send(16'd1);
    wait_idle();
    half_rate = 1'b0;
    @(negedge clk);

    // R2: pause disabled, and zero quantum when idle
    pause_en = 1'b0;
    send(16'd3);
    @(negedge clk);
    check("R2 disabled", tx_paused, 0);
    pause_en = 1'b1;
    send(16'd0);
    @(negedge clk);
    check("R2 zero idle", tx_paused, 0);

    // R10: negotiated flow control, idle and active
    pfc_done = 1'b1;
    send(16'd7);
    @(negedge clk);
    check("R10 idle", tx_paused, 0);
    pfc_done = 1'b0;
    test_fast = 1'b1;
    expect_pause(10, "R10 active");
    send(16'd10);
    repeat (2) @(negedge clk);
    pfc_done = 1'b1;
    send(16'd100);
    pfc_done = 1'b0;
    wait_idle();

    // R5: reload part way through
    expect_pause(10, "R5 reload");
    send(16'd20);
    repeat (5) @(negedge clk);
    send(16'd4);
    wait_idle();
    test_fast = 1'b0;

    // R6: zero quantum clears an active pause
    expect_pause(4, "R6 zero clear");
    send(16'd50);
    repeat (3) @(negedge clk);
    send(16'd0);
    wait_idle();

    // R7: start request held across a pause
    test_fast = 1'b1;
    expect_pause(6, "R7 length");
    send(16'd6);
    tx_start_valid = 1'b1;
    check("R7 ready low", tx_start_ready, 0);
    do @(negedge clk); while (tx_paused);
    check("R7 ready after", tx_start_ready, 1);
    @(negedge clk);
    tx_start_valid = 1'b0;
    test_fast = 1'b0;

    // R8: every event counted
    check("R8 count", pframe_count, exp_stat);

    // R9: saturation
    pause_en = 1'b0;
    repeat (6) send(16'd1);
    @(negedge clk);
    check("R9 saturate", pframe_count, 15);
    check("R9 expected beyond", exp_stat > 15, 1);

    repeat (2) @(negedge clk);
    check("scoreboard drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule